// File: doc/BRIEF.md
# Processor I/O Port with Charge Decay

This block is the small on-chip I/O port of an 8-bit processor, seen by the CPU at two bus addresses: address 0 holds the per-bit direction register (1 = output) and address 1 holds the data latch. The low bits have pins. When such a bit is an input, a read returns the pin level. The top two bits have no pins. When one of them is an input, a read returns a retained value that stands in for charge left on a floating node. That value is loaded from the last driven level. It falls to 0 once a programmable number of enabled cycles has passed without a new load.

The low three bits of the port also select the memory map. The block drives a banking code in which every input bit counts as 1, and it flags each change of that code with a one-cycle pulse. Every write to the port also places the last byte seen on the video bus into a shadow byte for the RAM cell under that address, so the written value never reaches the shadow.

Top module: `cpu_port_decay`

## Requirements
- R1: After reset the direction register is 0x00, the data latch is 0x3F, both retained bits are 0 with no timer running, the banking code is 3'b111, the change pulse is low and both shadow bytes are 0x00.
- R2: A read with address 0 returns the direction register. A read with address 1 returns the data latch on every bit whose direction is 1.
- R3: On a read of address 1, each pin bit (bits 0 to 5) whose direction is 0 returns the corresponding pin input.
- R4: On a read of address 1, bit 6 or 7 with direction 0 returns its retained value. A write to address 1 loads the written bit into the retained value only where that bit's direction is 1. Where it is 0, the retained value is left unchanged.
- R5: A write to address 0 that turns bit 6 or 7 from output (1) to input (0) copies the current data-latch bit into that retained value.
- R6: A retained bit is cleared to 0 on the DECAY_CYCLES-th clock edge with cyc_en high after its last load. Edges with cyc_en low do not count.
- R7: Bits 6 and 7 each have their own timer and retained value. One bit expiring or reloading leaves the other unchanged.
- R8: bank_sel equals bits 2..0 of (~direction | data).
- R9: bank_chg is high for exactly the one cycle after a clock edge that changes bank_sel, and low otherwise.
- R10: A write to address 0 stores vbus_last into shadow_lo. A write to address 1 stores vbus_last into shadow_hi. The written data never reaches either shadow byte.
- R11: Each load of a retained bit (a data write with output direction, or an output-to-input switch) restarts that bit's timer at DECAY_CYCLES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_en | input | 1 | Advances the decay timers by one count |
| acc_we | input | 1 | Write strobe for the port |
| acc_addr | input | 1 | 0 = direction register, 1 = data register |
| acc_wdata | input | 8 | Write data |
| vbus_last | input | 8 | Last byte seen on the video bus |
| pin_in | input | 6 | Pin levels of bits 0 to 5 |
| rd_data | output | 8 | Read data for acc_addr |
| bank_sel | output | 3 | Banking code for the memory decoder |
| bank_chg | output | 1 | One-cycle pulse on a banking code change |
| shadow_lo | output | 8 | RAM byte under address 0 |
| shadow_hi | output | 8 | RAM byte under address 1 |

## Verification
A wrong timer count shows on reads of address 1 as a floating bit that drops to 0 one or more edges early or late. Directed runs sample the exact edge before and the exact edge of expiry, with cyc_en both gated and free-running. A wrong capture or a wrong load on an input-direction write shows up on the first read after that write. The checks cover bit 6 and bit 7 expiring at different times. A stale banking code or a missing change pulse is visible in the cycle right after the write. Random traffic is compared against a reference model every cycle, so any divergence is reported within one clock.

// File: rtl/cpu_port_pkg.sv
package cpu_port_pkg;

   typedef enum logic {
      REG_DIR  = 1'b0,
      REG_DATA = 1'b1
   } port_reg_e;

   localparam int unsigned PORT_W_DEF   = 8;
   localparam int unsigned FLOAT_LO_DEF = 6;
   localparam int unsigned BANK_W_DEF   = 3;

endpackage

// File: rtl/cpu_port_decay_cell.sv
module cpu_port_decay_cell #(
   parameter int unsigned DECAY_CYCLES = 350000,
   localparam int unsigned CNT_W = $clog2(DECAY_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cyc_en,
   input  logic load,
   input  logic load_val,
   output logic held
);

   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DECAY_CYCLES);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic             live_q;

   generate
      if (DECAY_CYCLES < 1) begin : g_bad_decay
         $error("DECAY_CYCLES must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         live_q <= 1'b0;
         held   <= 1'b0;
      end else if (load) begin
         cnt_q  <= CNT_FULL;
         live_q <= 1'b1;
         held   <= load_val;
      end else if (live_q && cyc_en) begin
         if (cnt_q == CNT_LAST) begin
            cnt_q  <= '0;
            live_q <= 1'b0;
            held   <= 1'b0;
         end else begin
            cnt_q <= cnt_q - CNT_LAST;
         end
      end
   end

   // R11: every load restarts the full window
   assert_load_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (live_q && cnt_q == CNT_FULL));

   // R6: an idle cell holds no charge
   assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !live_q |-> !held);

   // R6: gated cycles do not advance the timer
   assert_pause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cyc_en && !load) |=> $stable(cnt_q));

   // R4: without a load the retained value can only fall to 0
   assert_no_spurious_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> (held == $past(held) || !held));

endmodule

// File: rtl/cpu_port_bank_watch.sv
module cpu_port_bank_watch #(
   parameter int unsigned          BANK_W   = 3,
   parameter logic [BANK_W-1:0]    RST_BANK = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BANK_W-1:0] bank_now,
   output logic              bank_chg
);

   logic [BANK_W-1:0] bank_seen_q;

   always_ff @(posedge clk) begin
      if (!rst_n) bank_seen_q <= RST_BANK;
      else        bank_seen_q <= bank_now;
   end

   assign bank_chg = (bank_now != bank_seen_q);

endmodule

// File: rtl/cpu_port_decay.sv
module cpu_port_decay
   import cpu_port_pkg::*;
#(
   parameter int unsigned     PORT_W       = PORT_W_DEF,
   parameter int unsigned     FLOAT_LO     = FLOAT_LO_DEF,
   parameter int unsigned     BANK_W       = BANK_W_DEF,
   parameter int unsigned     DECAY_CYCLES = 350000,
   parameter logic [7:0]      DATA_RST     = 8'h3F,
   localparam int unsigned    PIN_W        = FLOAT_LO
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_en,
   input  logic              acc_we,
   input  logic              acc_addr,
   input  logic [PORT_W-1:0] acc_wdata,
   input  logic [PORT_W-1:0] vbus_last,
   input  logic [PIN_W-1:0]  pin_in,
   output logic [PORT_W-1:0] rd_data,
   output logic [BANK_W-1:0] bank_sel,
   output logic              bank_chg,
   output logic [PORT_W-1:0] shadow_lo,
   output logic [PORT_W-1:0] shadow_hi
);

   localparam logic [PORT_W-1:0] DATA_INIT = PORT_W'(DATA_RST);
   localparam logic [PORT_W-1:0] BANK_ALL  = ~'0 | DATA_INIT;
   localparam logic [BANK_W-1:0] BANK_INIT = BANK_ALL[BANK_W-1:0];

   generate
      if (FLOAT_LO < 1 || FLOAT_LO >= PORT_W) begin : g_bad_float
         $error("FLOAT_LO must leave at least one pin bit and one floating bit");
      end
      if (BANK_W < 1 || BANK_W > FLOAT_LO) begin : g_bad_bank
         $error("BANK_W must fit in the pin bits");
      end
   endgenerate

   port_reg_e         sel;
   logic              wr_dir;
   logic              wr_dat;
   logic [PORT_W-1:0] dir_q;
   logic [PORT_W-1:0] data_q;
   logic [PORT_W-1:0] held_v;
   logic [PORT_W-1:0] port_view;
   logic [PORT_W-1:0] bank_wide;

   assign sel    = port_reg_e'(acc_addr);
   assign wr_dir = acc_we && (sel == REG_DIR);
   assign wr_dat = acc_we && (sel == REG_DATA);

   // register file and shadow RAM bytes
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q     <= '0;
         data_q    <= DATA_INIT;
         shadow_lo <= '0;
         shadow_hi <= '0;
      end else begin
         if (wr_dir) begin
            dir_q     <= acc_wdata;
            shadow_lo <= vbus_last;
         end
         if (wr_dat) begin
            data_q    <= acc_wdata;
            shadow_hi <= vbus_last;
         end
      end
   end

   // per-bit read path: pins below FLOAT_LO, retained charge above
   generate
      for (genvar i = 0; i < PORT_W; i++) begin : g_bit
         if (i < FLOAT_LO) begin : g_pin
            assign held_v[i]    = 1'b0;
            assign port_view[i] = dir_q[i] ? data_q[i] : pin_in[i];
         end else begin : g_float
            logic ld;
            logic ld_val;
            assign ld     = (wr_dat && dir_q[i]) ||
                            (wr_dir && dir_q[i] && !acc_wdata[i]);
            assign ld_val = wr_dat ? acc_wdata[i] : data_q[i];

            cpu_port_decay_cell #(
               .DECAY_CYCLES(DECAY_CYCLES)
            ) u_cell (
               .clk     (clk),
               .rst_n   (rst_n),
               .cyc_en  (cyc_en),
               .load    (ld),
               .load_val(ld_val),
               .held    (held_v[i])
            );

            assign port_view[i] = dir_q[i] ? data_q[i] : held_v[i];

            // R4: a data write onto an input bit leaves its retained value
            assert_input_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
               (wr_dat && !dir_q[i]) |=> (held_v[i] == $past(held_v[i]) || !held_v[i]));
         end
      end
   endgenerate

   assign rd_data   = (sel == REG_DIR) ? dir_q : port_view;
   assign bank_wide = ~dir_q | data_q;
   assign bank_sel  = bank_wide[BANK_W-1:0];

   cpu_port_bank_watch #(
      .BANK_W  (BANK_W),
      .RST_BANK(BANK_INIT)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .bank_now(bank_sel),
      .bank_chg(bank_chg)
   );

   // R10: the shadow byte takes the video bus, not the write data
   assert_shadow_lo_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dir |=> (shadow_lo == $past(vbus_last)));

   assert_shadow_hi_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dat |=> (shadow_hi == $past(vbus_last)));

   // R9: no write, no change pulse in the following cycle
   assert_quiet_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_we |=> !bank_chg);

   // R8: banking code moves only after a port write
   assert_bank_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_we |=> $stable(bank_sel));

endmodule

// File: tb/tb_cpu_port_decay.sv
module tb_cpu_port_decay;

   localparam int CLK_PERIOD = 10;
   localparam int DECAY      = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cyc_en = 1'b0;
   logic       acc_we = 1'b0;
   logic       acc_addr = 1'b0;
   logic [7:0] acc_wdata = 8'h00;
   logic [7:0] vbus_last = 8'h00;
   logic [5:0] pin_in = 6'h00;
   logic [7:0] rd_data;
   logic [2:0] bank_sel;
   logic       bank_chg;
   logic [7:0] shadow_lo;
   logic [7:0] shadow_hi;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   // reference model state
   logic [7:0] m_dir, m_dat, m_sh0, m_sh1;
   logic [2:0] m_prev;
   logic       m_held [2];
   logic       m_live [2];
   int         m_cnt  [2];

   cpu_port_decay #(.DECAY_CYCLES(DECAY)) dut (
      .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .acc_we(acc_we),
      .acc_addr(acc_addr), .acc_wdata(acc_wdata), .vbus_last(vbus_last),
      .pin_in(pin_in), .rd_data(rd_data), .bank_sel(bank_sel),
      .bank_chg(bank_chg), .shadow_lo(shadow_lo), .shadow_hi(shadow_hi)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [2:0] exp_bank(logic [7:0] d, logic [7:0] v);
      logic [7:0] w = ~d | v;
      return w[2:0];
   endfunction

   function automatic logic [7:0] exp_read(logic a, logic [5:0] p);
      logic [7:0] r;
      if (!a) return m_dir;
      for (int i = 0; i < 8; i++) begin
         if (m_dir[i]) r[i] = m_dat[i];
         else if (i < 6) r[i] = p[i];
         else r[i] = m_held[i-6];
      end
      return r;
   endfunction

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_dir = 8'h00; m_dat = 8'h3F; m_sh0 = 8'h00; m_sh1 = 8'h00;
      m_prev = 3'b111;
      for (int k = 0; k < 2; k++) begin
         m_held[k] = 1'b0; m_live[k] = 1'b0; m_cnt[k] = 0;
      end
   endtask

   task automatic model_edge(logic we, logic a, logic [7:0] wd, logic [7:0] vid, logic en);
      m_prev = exp_bank(m_dir, m_dat);
      for (int k = 0; k < 2; k++) begin
         int b = k + 6;
         logic ld = (we && a && m_dir[b]) || (we && !a && m_dir[b] && !wd[b]);
         if (ld) begin
            m_held[k] = a ? wd[b] : m_dat[b];
            m_live[k] = 1'b1;
            m_cnt[k]  = DECAY;
         end else if (m_live[k] && en) begin
            if (m_cnt[k] == 1) begin
               m_live[k] = 1'b0; m_held[k] = 1'b0; m_cnt[k] = 0;
            end else begin
               m_cnt[k]--;
            end
         end
      end
      if (we && !a) begin m_dir = wd; m_sh0 = vid; end
      if (we && a)  begin m_dat = wd; m_sh1 = vid; end
   endtask

   // one cycle: drive at negedge, model at posedge, compare a quarter period later
   task automatic tick(logic we, logic a, logic [7:0] wd, logic [7:0] vid, logic en, logic [5:0] p);
      @(negedge clk);
      acc_we = we; acc_addr = a; acc_wdata = wd; vbus_last = vid; cyc_en = en; pin_in = p;
      @(posedge clk);
      model_edge(we, a, wd, vid, en);
      #(CLK_PERIOD/4);
      chk(a ? "R3/R4/R5/R6/R7/R11 read" : "R2 read", rd_data, exp_read(a, p));
      chk("R8 bank", {5'b0, bank_sel}, {5'b0, exp_bank(m_dir, m_dat)});
      chk("R9 pulse", {7'b0, bank_chg}, {7'b0, (exp_bank(m_dir, m_dat) != m_prev)});
      chk("R10 shadow_lo", shadow_lo, m_sh0);
      chk("R10 shadow_hi", shadow_hi, m_sh1);
   endtask

   task automatic idle(int n, logic en);
      for (int i = 0; i < n; i++) tick(1'b0, 1'b1, 8'h00, 8'h00, en, 6'h15);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0C64));
      model_reset();
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      tick(1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 6'h15);
      chk("R1 dir", rd_data, 8'h00);
      chk("R1 bank", {5'b0, bank_sel}, 8'h07);
      chk("R1 pulse", {7'b0, bank_chg}, 8'h00);
      chk("R1 shadow", shadow_lo | shadow_hi, 8'h00);
      tick(1'b0, 1'b1, 8'h00, 8'h00, 1'b1, 6'h15);
      chk("R1 data view", rd_data, 8'h15);

      // R2 / R8 / R9: all outputs
      tick(1'b1, 1'b0, 8'hFF, 8'h11, 1'b1, 6'h15);
      chk("R9 no change on dir write", {7'b0, bank_chg}, 8'h00);
      tick(1'b1, 1'b1, 8'hA5, 8'h22, 1'b1, 6'h15);
      chk("R9 pulse high", {7'b0, bank_chg}, 8'h01);
      chk("R8 bank", {5'b0, bank_sel}, 8'h05);
      tick(1'b0, 1'b1, 8'h00, 8'h00, 1'b1, 6'h15);
      chk("R9 pulse one cycle", {7'b0, bank_chg}, 8'h00);
      chk("R2 data", rd_data, 8'hA5);
      tick(1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 6'h15);
      chk("R2 dir", rd_data, 8'hFF);

      // R5 capture, R3 pins, R6 pause and expiry
      tick(1'b1, 1'b0, 8'h00, 8'h33, 1'b1, 6'h15);
      idle(50, 1'b0);
      chk("R5 capture / R6 pause", rd_data, 8'h95);
      idle(DECAY - 1, 1'b1);
      chk("R6 before expiry", rd_data, 8'h95);
      idle(1, 1'b1);
      chk("R6 expired", rd_data, 8'h15);

      // R4: data write onto input bits does not load
      tick(1'b1, 1'b1, 8'hC0, 8'h44, 1'b1, 6'h15);
      chk("R4 ignored", rd_data, 8'h15);

      // R7 / R11: independent timers and restart
      tick(1'b1, 1'b0, 8'hC0, 8'h00, 1'b1, 6'h15);
      tick(1'b1, 1'b1, 8'h40, 8'h00, 1'b1, 6'h15);
      tick(1'b1, 1'b0, 8'h00, 8'h00, 1'b1, 6'h15);
      tick(1'b0, 1'b1, 8'h00, 8'h00, 1'b1, 6'h15);
      chk("R5 two-bit capture", rd_data, 8'h55);
      idle(DECAY/2 - 1, 1'b1);
      tick(1'b1, 1'b0, 8'h80, 8'h00, 1'b1, 6'h15);
      tick(1'b1, 1'b1, 8'h80, 8'h00, 1'b1, 6'h15);
      tick(1'b1, 1'b0, 8'h00, 8'h00, 1'b1, 6'h15);
      idle(16, 1'b1);
      chk("R7 both held", rd_data, 8'hD5);
      idle(1, 1'b1);
      chk("R7 bit6 expired alone", rd_data, 8'h95);
      idle(22, 1'b1);
      chk("R11 bit7 restarted", rd_data, 8'h95);
      idle(1, 1'b1);
      chk("R11 bit7 expired", rd_data, 8'h15);

      // R10: shadows take the video bus
      tick(1'b1, 1'b0, 8'h00, 8'h5A, 1'b1, 6'h15);
      chk("R10 shadow_lo", shadow_lo, 8'h5A);
      tick(1'b1, 1'b1, 8'h3C, 8'hE1, 1'b1, 6'h15);
      chk("R10 shadow_hi", shadow_hi, 8'hE1);

      // random traffic against the model
      for (int i = 0; i < 3000; i++) begin
         logic we = ($urandom_range(0, 9) < 3);
         logic a  = $urandom_range(0, 1);
         logic [7:0] wd  = 8'($urandom);
         logic [7:0] vid = 8'($urandom);
         logic en = ($urandom_range(0, 9) < 8);
         logic [5:0] p = 6'($urandom);
         if (a == 1'b0 && $urandom_range(0, 1) == 1) wd[7:6] = 2'b00;
         tick(we, a, wd, vid, en, p);
      end

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule